// File: doc/BRIEF.md
# Dadda Reduction-Tree Unsigned Multiplier

This block multiplies two unsigned operands in pure combinational logic and returns the full double-width product in the same cycle the operands are presented. Each pair of operand bits is ANDed into a dot matrix: for 8-bit operands that is 64 partial-product bits spread over 15 weighted columns. The columns are then compressed by layers of 3-input and 2-input counters (full and half adders) until no column holds more than two bits. A ripple carry-propagate adder then sums the two remaining rows into the product.

The compression follows the Dadda height schedule. Each layer brings the tallest column down only to the next height in the sequence 2, 3, 4, 6, 9, 13, ..., taken in descending order. For 8-bit operands the targets are 6, then 4, then 3, then 2. In every layer, counters are placed from the least significant column upward. A column's budget includes the carries that the column below will deliver to it in the next layer. As a result, the layer uses only as many counters as it must. At 8 bits the tree holds 35 full adders and 7 half adders, and the final adder spans 14 columns. Elaboration-time checks in the top module enforce these totals. No multiply operator appears in the datapath; every counter is an explicit adder cell instance.

The operand width is a parameter. The counter placement for every layer is computed at elaboration by constant functions, so other widths produce their own Dadda schedule without a hand-written netlist.

Top module: `dadda_mult`

## Requirements
- R1: For every pair of 8-bit unsigned operands, `prod` equals the exact unsigned product of `opa` and `opb`. The product is 16 bits wide with bit 15 as its most significant bit.
- R2: When either operand is zero, `prod` is zero.
- R3: Bit 0 of `prod` equals the AND of bit 0 of `opa` and bit 0 of `opb`.
- R4: When one operand equals 1, `prod` equals the other operand zero-extended to 16 bits.
- R5: When both operands are all ones (255), `prod` is 16'hFE01, the largest product.
- R6: When one operand is a power of two, 2^k with k in 0..7, `prod` equals the other operand shifted left by k bit positions. Its count of set bits therefore equals that of the other operand.
- R7: Exchanging the two operands leaves `prod` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 (N) | First unsigned operand |
| opb | input | 8 (N) | Second unsigned operand |
| prod | output | 16 (2N) | Unsigned product, combinational |

## Verification
The bound checker re-evaluates the product on every change of the operands. It compares the product against exact unsigned arithmetic (R1) and checks the zero-operand (R2), low-bit (R3), unit-operand (R4), all-ones (R5) and power-of-two (R6) identities at the ports. Operand symmetry (R7) relates two different input pairs, so only the bench can show it. The bench records the full 65,536-entry product table during an exhaustive sweep and then compares each entry with its transposed pair. The exhaustive sweep also gives the only direct evidence that every carry path in the compression layers and in the 14-column final adder is wired to the correct column.

// File: rtl/dadda_pkg.sv
package dadda_pkg;

   // Largest operand width the elaboration planner supports.
   localparam int MAX_N = 32;

   // Plan query selectors.
   localparam int Q_HEIGHT = 0;
   localparam int Q_FULL   = 1;
   localparam int Q_HALF   = 2;
   localparam int Q_CIN    = 3;

   // Number of compression layers: how many schedule heights lie below n.
   function automatic int dd_stages(input int n);
      int d;
      int k;
      d = 2;
      k = 0;
      while (d < n) begin
         k = k + 1;
         d = (d * 3) / 2;
      end
      return k;
   endfunction

   // Target height of layer s (layer 0 is the first, tallest target).
   function automatic int dd_target(input int n, input int s);
      int d;
      int idx;
      d   = 2;
      idx = dd_stages(n) - 1 - s;
      for (int j = 0; j < idx; j++) begin
         d = (d * 3) / 2;
      end
      return d;
   endfunction

   // Replays the whole reduction and answers one query for layer s, column c:
   // the column height entering layer s, the full or half adders placed
   // there, or the carries arriving from column c-1 in that layer.
   function automatic int dd_plan(input int n, input int s, input int c, input int kind);
      int h   [2*MAX_N];
      int hn  [2*MAX_N];
      int res;
      int cin;
      int e;
      int f;
      int hh;
      int d;
      int k;
      res = 0;
      k   = dd_stages(n);
      for (int col = 0; col < 2*MAX_N; col++) begin
         if (col < 2*n - 1) h[col] = (col < n) ? col + 1 : 2*n - 1 - col;
         else               h[col] = 0;
         hn[col] = 0;
      end
      for (int st = 0; st <= k; st++) begin
         if (st == s && kind == Q_HEIGHT) res = h[c];
         if (st < k && st <= s) begin
            d   = dd_target(n, st);
            cin = 0;
            for (int col = 0; col < 2*n; col++) begin
               e  = h[col] + cin - d;
               f  = (e > 0) ? e / 2 : 0;
               hh = (e > 0) ? e % 2 : 0;
               if (st == s && col == c) begin
                  if (kind == Q_FULL)      res = f;
                  else if (kind == Q_HALF) res = hh;
                  else if (kind == Q_CIN)  res = cin;
               end
               hn[col] = (e > 0) ? d : h[col] + cin;
               cin     = f + hh;
            end
            for (int col = 0; col < 2*n; col++) begin
               h[col] = hn[col];
            end
         end
      end
      return res;
   endfunction

   function automatic int dd_count(input int n, input int kind);
      int tot;
      tot = 0;
      for (int s = 0; s < dd_stages(n); s++) begin
         for (int c = 0; c < 2*n; c++) begin
            tot = tot + dd_plan(n, s, c, kind);
         end
      end
      return tot;
   endfunction

   // Lowest and highest columns that still hold two bits after compression.
   function automatic int dd_cpa_lo(input int n);
      int r;
      r = 2*n;
      for (int c = 2*n - 1; c >= 0; c--) begin
         if (dd_plan(n, dd_stages(n), c, Q_HEIGHT) == 2) r = c;
      end
      return r;
   endfunction

   function automatic int dd_cpa_hi(input int n);
      int r;
      r = -1;
      for (int c = 0; c < 2*n; c++) begin
         if (dd_plan(n, dd_stages(n), c, Q_HEIGHT) == 2) r = c;
      end
      return r;
   endfunction

endpackage

// File: rtl/dadda_fa.sv
module dadda_fa (
   input  logic x,
   input  logic y,
   input  logic z,
   output logic s,
   output logic co
);
   assign s  = x ^ y ^ z;
   assign co = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/dadda_ha.sv
module dadda_ha (
   input  logic x,
   input  logic y,
   output logic s,
   output logic co
);
   assign s  = x ^ y;
   assign co = x & y;
endmodule

// File: rtl/dadda_ppgen.sv
module dadda_ppgen #(
   parameter int N = 8
) (
   input  logic [N-1:0]            a,
   input  logic [N-1:0]            b,
   output logic [2*N-1:0][N-1:0]   mat
);
   localparam int COLS = 2 * N;

   genvar c, t;
   for (c = 0; c < COLS; c++) begin : g_col
      localparam int LOI = (c < N) ? 0 : c - N + 1;
      localparam int HII = (c < N) ? c : N - 1;
      for (t = 0; t < N; t++) begin : g_slot
         if (t <= HII - LOI) begin : g_dot
            assign mat[c][t] = a[LOI + t] & b[c - LOI - t];
         end else begin : g_empty
            assign mat[c][t] = 1'b0;
         end
      end
   end
endmodule

// File: rtl/dadda_stage.sv
module dadda_stage
   import dadda_pkg::*;
#(
   parameter int N = 8,
   parameter int S = 0
) (
   input  logic [2*N-1:0][N-1:0] mi,
   output logic [2*N-1:0][N-1:0] mo
);
   localparam int COLS = 2 * N;

   wire unused_mi = ^mi;

   genvar c, j, t;
   for (c = 0; c < COLS; c++) begin : g_col
      localparam int HIN  = dd_plan(N, S, c, Q_HEIGHT);
      localparam int NF   = dd_plan(N, S, c, Q_FULL);
      localparam int NH   = dd_plan(N, S, c, Q_HALF);
      localparam int CIN  = dd_plan(N, S, c, Q_CIN);
      localparam int NP   = HIN - 3*NF - 2*NH;
      localparam int HOUT = CIN + NF + NH + NP;

      if (HOUT > N || NP < 0) begin : g_bad_plan
         initial $fatal(1, "dadda_stage: column %0d overflows in layer %0d", c, S);
      end

      // Output slot order: incoming carries, then sums, then passed bits.
      for (j = 0; j < NF; j++) begin : g_fa
         logic co;
         dadda_fa u_fa (
            .x  (mi[c][3*j]),
            .y  (mi[c][3*j+1]),
            .z  (mi[c][3*j+2]),
            .s  (mo[c][CIN+j]),
            .co (co)
         );
         if (c + 1 < COLS) begin : g_carry
            assign mo[c+1][j] = co;
         end else begin : g_drop
            wire unused_co = co;
         end
      end

      if (NH == 1) begin : g_ha
         logic co;
         dadda_ha u_ha (
            .x  (mi[c][3*NF]),
            .y  (mi[c][3*NF+1]),
            .s  (mo[c][CIN+NF]),
            .co (co)
         );
         if (c + 1 < COLS) begin : g_carry
            assign mo[c+1][NF] = co;
         end else begin : g_drop
            wire unused_co = co;
         end
      end

      for (t = 0; t < NP; t++) begin : g_pass
         assign mo[c][CIN+NF+NH+t] = mi[c][3*NF+2*NH+t];
      end

      for (t = HOUT; t < N; t++) begin : g_zero
         assign mo[c][t] = 1'b0;
      end
   end
endmodule

// File: rtl/dadda_cpa.sv
module dadda_cpa
   import dadda_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [2*N-1:0][N-1:0] mat,
   output logic [2*N-1:0]        prod
);
   localparam int COLS = 2 * N;
   localparam int K    = dd_stages(N);
   localparam int LO   = dd_cpa_lo(N);

   logic [COLS:0] cy;
   assign cy[0] = 1'b0;

   wire unused_cpa = ^{cy, mat};

   genvar c;
   for (c = 0; c < COLS; c++) begin : g_col
      localparam int H = dd_plan(N, K, c, Q_HEIGHT);

      if (H > 2) begin : g_bad_height
         initial $fatal(1, "dadda_cpa: column %0d left with %0d bits", c, H);
      end

      if (c < LO) begin : g_low
         assign prod[c]  = mat[c][0];
         assign cy[c+1]  = 1'b0;
      end else if (H == 2 && c == LO) begin : g_first
         dadda_ha u_ha (
            .x  (mat[c][0]),
            .y  (mat[c][1]),
            .s  (prod[c]),
            .co (cy[c+1])
         );
      end else if (H == 2) begin : g_two
         dadda_fa u_fa (
            .x  (mat[c][0]),
            .y  (mat[c][1]),
            .z  (cy[c]),
            .s  (prod[c]),
            .co (cy[c+1])
         );
      end else if (H == 1) begin : g_one
         dadda_ha u_ha (
            .x  (mat[c][0]),
            .y  (cy[c]),
            .s  (prod[c]),
            .co (cy[c+1])
         );
      end else begin : g_none
         assign prod[c] = cy[c];
         assign cy[c+1] = 1'b0;
      end
   end
endmodule

// File: rtl/dadda_mult.sv
module dadda_mult
   import dadda_pkg::*;
#(
   parameter int N = 8
) (
   input  logic [N-1:0]   opa,
   input  logic [N-1:0]   opb,
   output logic [2*N-1:0] prod
);
   localparam int COLS     = 2 * N;
   localparam int K        = dd_stages(N);
   localparam int FA_TOTAL = dd_count(N, Q_FULL);
   localparam int HA_TOTAL = dd_count(N, Q_HALF);
   localparam int CPA_W    = dd_cpa_hi(N) - dd_cpa_lo(N) + 1;

   if (N < 2 || N > MAX_N) begin : g_bad_width
      initial $fatal(1, "dadda_mult: N=%0d outside 2..%0d", N, MAX_N);
   end

   if (N == 8) begin : g_check8
      if (K != 4 || dd_target(N, 0) != 6 || dd_target(N, 1) != 4 ||
          dd_target(N, 2) != 3 || dd_target(N, 3) != 2) begin : g_bad_sched
         initial $fatal(1, "dadda_mult: height schedule is not 6,4,3,2");
      end
      if (FA_TOTAL != 35 || HA_TOTAL != 7 || CPA_W != 14) begin : g_bad_count
         initial $fatal(1, "dadda_mult: %0d FA, %0d HA, %0d-bit adder", FA_TOTAL, HA_TOTAL, CPA_W);
      end
   end

   logic [COLS-1:0][N-1:0] pp;
   logic [COLS-1:0][N-1:0] fin;

   dadda_ppgen #(.N(N)) u_ppgen (
      .a   (opa),
      .b   (opb),
      .mat (pp)
   );

   genvar s;
   for (s = 0; s < K; s++) begin : g_stg
      logic [COLS-1:0][N-1:0] m;
      if (s == 0) begin : g_head
         dadda_stage #(.N(N), .S(s)) u_stage (.mi(pp), .mo(m));
      end else begin : g_tail
         dadda_stage #(.N(N), .S(s)) u_stage (.mi(g_stg[s-1].m), .mo(m));
      end
   end

   if (K == 0) begin : g_no_tree
      assign fin = pp;
   end else begin : g_tree
      assign fin = g_stg[K-1].m;
   end

   dadda_cpa #(.N(N)) u_cpa (
      .mat  (fin),
      .prod (prod)
   );
endmodule

// File: rtl/dadda_mult_chk.sv
module dadda_mult_chk #(
   parameter int N = 8
) (
   input logic [N-1:0]   a,
   input logic [N-1:0]   b,
   input logic [2*N-1:0] p
);
   localparam logic [2*N-1:0] ONES = {{N{1'b0}}, {N{1'b1}}};
   localparam logic [2*N-1:0] PMAX = ONES * ONES;

   always_comb begin
      // R1: exact unsigned product
      p_exact_r1: assert (p == ({{N{1'b0}}, a} * {{N{1'b0}}, b}))
         else $error("R1 product %h for %h*%h", p, a, b);
      // R2: zero operand gives zero product
      if (a == '0 || b == '0) begin
         p_zero_r2: assert (p == '0)
            else $error("R2 product %h with zero operand", p);
      end
      // R3: low product bit
      p_lsb_r3: assert (p[0] == (a[0] & b[0]))
         else $error("R3 low bit %b", p[0]);
      // R4: unit operand passes the other through
      if (a == N'(1)) begin
         p_unit_a_r4: assert (p == {{N{1'b0}}, b})
            else $error("R4 product %h, b=%h", p, b);
      end
      if (b == N'(1)) begin
         p_unit_b_r4: assert (p == {{N{1'b0}}, a})
            else $error("R4 product %h, a=%h", p, a);
      end
      // R5: all-ones operands
      if (&a && &b) begin
         p_max_r5: assert (p == PMAX)
            else $error("R5 product %h", p);
      end
      // R6: power-of-two operand only shifts the other
      if ($countones(b) == 1) begin
         p_pow2_b_r6: assert ($countones(p) == $countones(a))
            else $error("R6 product %h, a=%h b=%h", p, a, b);
      end
      if ($countones(a) == 1) begin
         p_pow2_a_r6: assert ($countones(p) == $countones(b))
            else $error("R6 product %h, a=%h b=%h", p, a, b);
      end
   end
endmodule

bind dadda_mult dadda_mult_chk #(.N(N)) u_chk (
   .a (opa),
   .b (opb),
   .p (prod)
);

// File: tb/dadda_mult_bench.sv
module dadda_mult_bench;
   logic        clk = 1'b0;
   logic        rst;
   logic [7:0]  opa;
   logic [7:0]  opb;
   logic [15:0] prod;
   int          checks = 0;
   int          errors = 0;
   bit          done   = 1'b0;
   logic [15:0] seen [0:65535];

   always #5 clk = ~clk;

   dadda_mult #(.N(8)) u_dadda_mult (
      .opa  (opa),
      .opb  (opb),
      .prod (prod)
   );

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: a=%0d b=%0d got %h expected %h", tag, opa, opb, act, exp);
      end
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      logic [15:0] expv;
      rst = 1'b1;
      opa = '0;
      opb = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R2 reset", prod, 16'h0000);
      rst = 1'b0;

      for (int ia = 0; ia < 256; ia++) begin
         for (int ib = 0; ib < 256; ib++) begin
            @(posedge clk);
            #1;
            opa  = 8'(ia);
            opb  = 8'(ib);
            expv = 16'(ia * ib);
            @(negedge clk);
            check("R1 exact", prod, expv);
            seen[ia*256 + ib] = prod;
            check("R3 lsb", {15'b0, prod[0]}, {15'b0, opa[0] & opb[0]});
            if (ia == 0 || ib == 0) check("R2 zero", prod, 16'h0000);
            if (ia == 1) check("R4 unit", prod, 16'(ib));
            if (ib == 1) check("R4 unit", prod, 16'(ia));
            if (ia == 255 && ib == 255) check("R5 max", prod, 16'hFE01);
            for (int k = 0; k < 8; k++) begin
               if (ib == (1 << k)) check("R6 pow2", prod, 16'(ia << k));
            end
         end
      end

      for (int ia = 0; ia < 256; ia++) begin
         for (int ib = ia + 1; ib < 256; ib++) begin
            check("R7 swap", seen[ia*256 + ib], seen[ib*256 + ia]);
         end
      end

      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got unfinished run expected completion");
         report();
         $finish;
      end
   end
endmodule